// File: doc/BRIEF.md
# Calibration Mode Sequencer

This block orders the measurement steps a converter takes when it runs normally and when it calibrates. A 3-bit mode field selects the activity. The sequencer then drives a source selector with one of three sources: the analog input, an internal short, or the reference. It asks the converter core for one measurement at a time. When the core reports that a measurement is finished, the sequencer advances.

A finished calibration step pulses a write strobe for either the zero-scale coefficient or the full-scale coefficient of the latched channel. When a single-command calibration completes, the sequencer clears the mode field back to normal and pulses ready once. In background mode it cycles through six measurement slots. Only one slot in each cycle is an input conversion, and only that slot pulses ready. The two access modes start no measurement. They only select which coefficient set is exposed for host access.

Top module: `calseq_top`

## Requirements
- R1: After reset, mode_o is 000 (normal), ch_o is 0, all pulse outputs are low, and a measurement is requested on the input (src_o = 00). Source encoding: 00 input, 01 internal short, 10 reference.
- R2: In mode 000 the source is the input and a measurement is always requested. Each accepted meas_done_i gives a one-cycle rdy_o in the next cycle, with no coefficient strobe, and the mode is unchanged.
- R3: Mode 001 measures the short first, and zs_wr_o follows that step. It then measures the reference, and fs_wr_o and rdy_o follow that step. With those pulses mode_o reads 000.
- R4: Mode 010 takes one input step and then pulses zs_wr_o and rdy_o. Mode 011 takes one input step and then pulses fs_wr_o and rdy_o. Both return mode_o to 000.
- R5: Mode 100 measures the input first, and zs_wr_o follows that step. It then measures the reference, and fs_wr_o, rdy_o and the return to 000 follow that step.
- R6: Mode 101 repeats six slots in the order input, short, reference, short, reference, short. Short slots pulse zs_wr_o and reference slots pulse fs_wr_o. Only the input slot pulses rdy_o. The mode stays 101.
- R7: Modes 110 and 111 request no measurement. They raise acc_zs_o or acc_fs_o respectively, and meas_done_i produces no pulse and no mode change.
- R8: A mode write (mode_wr_i) aborts any sequence in progress and restarts at the first step of the new mode. A meas_done_i in the same cycle as the write is discarded.
- R9: ch_o takes ch_i only on a mode write and holds it until the next write.
- R10: All pulse outputs appear in the cycle after the accepted meas_done_i, and zs_wr_o and fs_wr_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode field write strobe |
| mode_i | input | 3 | New mode value |
| ch_i | input | CH_W | Channel to latch with the mode |
| meas_done_i | input | 1 | Converter core finished the requested measurement |
| mode_o | output | 3 | Current mode field, self-clearing |
| ch_o | output | CH_W | Latched channel for the sequence |
| src_o | output | 2 | Measurement source select |
| meas_req_o | output | 1 | A measurement is wanted |
| zs_wr_o | output | 1 | Zero-scale coefficient write strobe |
| fs_wr_o | output | 1 | Full-scale coefficient write strobe |
| rdy_o | output | 1 | Ready pulse |
| acc_zs_o | output | 1 | Zero-scale coefficient access selected |
| acc_fs_o | output | 1 | Full-scale coefficient access selected |

## Verification
The assertions check several properties on every cycle. The two coefficient strobes are mutually exclusive. Every pulse is caused by a done that was accepted in the previous cycle while no write was pending. A mode change not caused by a write always lands on normal together with ready. Access modes never request a measurement, and the latched channel holds between writes. Some properties can only be shown by the bench scenarios: the source order of each mode, the six-slot background rotation and its wrap, the abort that restarts a sequence midway, and a write that collides with a done.

// File: rtl/calseq_pkg.sv
package calseq_pkg;
  typedef enum logic [2:0] {
    M_NORM   = 3'd0,
    M_SELF   = 3'd1,
    M_SYS_ZS = 3'd2,
    M_SYS_FS = 3'd3,
    M_OFFS   = 3'd4,
    M_BG     = 3'd5,
    M_ACC_ZS = 3'd6,
    M_ACC_FS = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    SRC_IN    = 2'd0,
    SRC_SHORT = 2'd1,
    SRC_REF   = 2'd2
  } src_e;

  typedef struct packed {
    src_e src;
    logic req;
    logic wr_zs;
    logic wr_fs;
    logic rdy;
    logic last;   // sequence ends, mode returns to normal
    logic wrap;   // step counter returns to zero, mode kept
  } step_t;
endpackage

// File: rtl/calseq_decode.sv
module calseq_decode
  import calseq_pkg::*;
#(
  parameter int BG_SLOTS = 6,
  parameter int STEP_W   = 3
) (
  input  mode_e             mode_i,
  input  logic [STEP_W-1:0] step_i,
  output step_t             step_o
);
  localparam logic [STEP_W-1:0] BG_LAST = STEP_W'(BG_SLOTS - 1);

  always_comb begin
    step_o = '{src: SRC_IN, req: 1'b0, wr_zs: 1'b0, wr_fs: 1'b0,
               rdy: 1'b0, last: 1'b0, wrap: 1'b0};
    unique case (mode_i)
      M_NORM: begin
        step_o.req  = 1'b1;
        step_o.rdy  = 1'b1;
        step_o.wrap = 1'b1;
      end
      M_SELF: begin
        step_o.req = 1'b1;
        if (step_i == '0) begin
          step_o.src   = SRC_SHORT;
          step_o.wr_zs = 1'b1;
        end else begin
          step_o.src   = SRC_REF;
          step_o.wr_fs = 1'b1;
          step_o.rdy   = 1'b1;
          step_o.last  = 1'b1;
        end
      end
      M_SYS_ZS: begin
        step_o.req   = 1'b1;
        step_o.wr_zs = 1'b1;
        step_o.rdy   = 1'b1;
        step_o.last  = 1'b1;
      end
      M_SYS_FS: begin
        step_o.req   = 1'b1;
        step_o.wr_fs = 1'b1;
        step_o.rdy   = 1'b1;
        step_o.last  = 1'b1;
      end
      M_OFFS: begin
        step_o.req = 1'b1;
        if (step_i == '0) begin
          step_o.wr_zs = 1'b1;
        end else begin
          step_o.src   = SRC_REF;
          step_o.wr_fs = 1'b1;
          step_o.rdy   = 1'b1;
          step_o.last  = 1'b1;
        end
      end
      M_BG: begin
        step_o.req  = 1'b1;
        step_o.wrap = (step_i == BG_LAST);
        if (step_i == '0) begin
          step_o.rdy = 1'b1;
        end else if (step_i[0]) begin
          step_o.src   = SRC_SHORT;
          step_o.wr_zs = 1'b1;
        end else begin
          step_o.src   = SRC_REF;
          step_o.wr_fs = 1'b1;
        end
      end
      default: ;  // coefficient access: no measurement
    endcase
  end
endmodule

// File: rtl/calseq_step_ctr.sv
module calseq_step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic              wrap_i,
  output logic [STEP_W-1:0] step_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 step_o <= '0;
    else if (clear_i)            step_o <= '0;
    else if (adv_i && wrap_i)    step_o <= '0;
    else if (adv_i)              step_o <= step_o + 1'b1;
  end
endmodule

// File: rtl/calseq_top.sv
module calseq_top
  import calseq_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int BG_SLOTS = 6,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int STEP_W  = (BG_SLOTS > 2) ? $clog2(BG_SLOTS) : 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_wr_i,
  input  logic [2:0]      mode_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            meas_done_i,
  output logic [2:0]      mode_o,
  output logic [CH_W-1:0] ch_o,
  output logic [1:0]      src_o,
  output logic            meas_req_o,
  output logic            zs_wr_o,
  output logic            fs_wr_o,
  output logic            rdy_o,
  output logic            acc_zs_o,
  output logic            acc_fs_o
);
  mode_e             mode_q;
  logic [CH_W-1:0]   ch_q;
  logic [STEP_W-1:0] step;
  step_t             dec;
  logic              adv;

  calseq_decode #(.BG_SLOTS(BG_SLOTS), .STEP_W(STEP_W)) i_decode (
    .mode_i (mode_q),
    .step_i (step),
    .step_o (dec)
  );

  // a write wins over a done in the same cycle
  assign adv = meas_done_i && dec.req && !mode_wr_i;

  calseq_step_ctr #(.STEP_W(STEP_W)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (mode_wr_i || (adv && dec.last)),
    .adv_i   (adv),
    .wrap_i  (dec.wrap),
    .step_o  (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_NORM;
      ch_q    <= '0;
      zs_wr_o <= 1'b0;
      fs_wr_o <= 1'b0;
      rdy_o   <= 1'b0;
    end else begin
      zs_wr_o <= adv && dec.wr_zs;
      fs_wr_o <= adv && dec.wr_fs;
      rdy_o   <= adv && dec.rdy;
      if (mode_wr_i) begin
        mode_q <= mode_e'(mode_i);
        ch_q   <= ch_i;
      end else if (adv && dec.last) begin
        mode_q <= M_NORM;
      end
    end
  end

  assign mode_o     = mode_q;
  assign ch_o       = ch_q;
  assign src_o      = dec.src;
  assign meas_req_o = dec.req;
  assign acc_zs_o   = (mode_q == M_ACC_ZS);
  assign acc_fs_o   = (mode_q == M_ACC_FS);
endmodule

// File: rtl/calseq_chk.sv
module calseq_chk #(
  parameter int CH_W = 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_wr_i,
  input logic            meas_done_i,
  input logic [2:0]      mode_o,
  input logic [CH_W-1:0] ch_o,
  input logic            meas_req_o,
  input logic            zs_wr_o,
  input logic            fs_wr_o,
  input logic            rdy_o,
  input logic            acc_zs_o,
  input logic            acc_fs_o
);
  AST_COEF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({zs_wr_o, fs_wr_o}));  // R10

  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zs_wr_o || fs_wr_o || rdy_o) |->
      $past(meas_done_i && meas_req_o && !mode_wr_i));  // R8

  AST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(mode_wr_i) && !$stable(mode_o)) |-> (mode_o == 3'd0 && rdy_o));  // R4

  AST_RDY_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (mode_o == 3'd0 || mode_o == 3'd5 || $past(mode_wr_i)));  // R2

  AST_ACCESS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_zs_o || acc_fs_o) |-> !meas_req_o);  // R7

  AST_CH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mode_wr_i) |-> $stable(ch_o));  // R9
endmodule

bind calseq_top calseq_chk #(.CH_W(CH_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_wr_i   (mode_wr_i),
  .meas_done_i (meas_done_i),
  .mode_o      (mode_o),
  .ch_o        (ch_o),
  .meas_req_o  (meas_req_o),
  .zs_wr_o     (zs_wr_o),
  .fs_wr_o     (fs_wr_o),
  .rdy_o       (rdy_o),
  .acc_zs_o    (acc_zs_o),
  .acc_fs_o    (acc_fs_o)
);

// File: tb/test_calseq_top.sv
module test_calseq_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_wr_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic [0:0] ch_i = 1'b0;
  logic       meas_done_i = 1'b0;
  logic [2:0] mode_o;
  logic [0:0] ch_o;
  logic [1:0] src_o;
  logic       meas_req_o, zs_wr_o, fs_wr_o, rdy_o, acc_zs_o, acc_fs_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #5 clk_i = ~clk_i;

  calseq_top i_calseq_top (.*);

  // {wr, mode[2:0], ch, src[1:0], req, zs, fs, rdy, mode_after[2:0]}
  localparam logic [13:0] VEC [14] = '{
    {1'b1, 3'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0},  // R2
    {1'b1, 3'd1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1},  // R3
    {1'b0, 3'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0},  // R3
    {1'b1, 3'd2, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0},  // R4
    {1'b1, 3'd3, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0},  // R4
    {1'b1, 3'd4, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4},  // R5
    {1'b0, 3'd0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0},  // R5
    {1'b1, 3'd5, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5},  // R6
    {1'b0, 3'd0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd5},
    {1'b0, 3'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5},
    {1'b0, 3'd0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd5},
    {1'b0, 3'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5},
    {1'b0, 3'd0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd5},
    {1'b0, 3'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5}   // R6 wrap
  };

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_mode(logic [2:0] m, logic c);
    @(negedge clk_i);
    mode_wr_i = 1'b1; mode_i = m; ch_i = c;
    @(negedge clk_i);
    mode_wr_i = 1'b0;
  endtask

  task automatic pulse_done();
    meas_done_i = 1'b1;
    @(negedge clk_i);
    meas_done_i = 1'b0;
  endtask

  task automatic chk_pulses(string req, logic zs, logic fs, logic rdy, logic [2:0] m);
    chk(req, "zs_wr_o", 8'(zs_wr_o), 8'(zs));
    chk(req, "fs_wr_o", 8'(fs_wr_o), 8'(fs));
    chk(req, "rdy_o", 8'(rdy_o), 8'(rdy));
    chk(req, "mode_o", 8'(mode_o), 8'(m));
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic cur_ch;
    cur_ch = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "mode_o", 8'(mode_o), 8'd0);
    chk("R1", "src_o", 8'(src_o), 8'd0);
    chk("R1", "meas_req_o", 8'(meas_req_o), 8'd1);
    chk("R1", "pulses", 8'({zs_wr_o, fs_wr_o, rdy_o}), 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "ch_o", 8'(ch_o), 8'd0);

    for (int i = 0; i < 14; i++) begin
      logic [13:0] v;
      v = VEC[i];
      if (v[13]) begin
        write_mode(v[12:10], v[9]);
        cur_ch = v[9];
      end
      @(negedge clk_i);
      chk("R9", "ch_o", 8'(ch_o), 8'(cur_ch));
      chk("R6", "src_o", 8'(src_o), 8'(v[8:7]));
      chk("R2", "meas_req_o", 8'(meas_req_o), 8'(v[6]));
      pulse_done();
      chk_pulses("R10", v[5], v[4], v[3], v[2:0]);
      @(negedge clk_i);
      chk("R10", "pulse width", 8'({zs_wr_o, fs_wr_o, rdy_o}), 8'd0);
    end

    // R8 abort mid self-cal into full-scale step
    write_mode(3'd1, 1'b0);
    pulse_done();
    chk_pulses("R8", 1'b1, 1'b0, 1'b0, 3'd1);
    write_mode(3'd3, 1'b1);
    chk("R8", "src_o", 8'(src_o), 8'd0);
    pulse_done();
    chk_pulses("R8", 1'b0, 1'b1, 1'b1, 3'd0);

    // R8 write colliding with done: done discarded, new mode starts at step 0
    write_mode(3'd4, 1'b0);
    @(negedge clk_i);
    mode_wr_i = 1'b1; mode_i = 3'd1; meas_done_i = 1'b1;
    @(negedge clk_i);
    mode_wr_i = 1'b0; meas_done_i = 1'b0;
    chk_pulses("R8", 1'b0, 1'b0, 1'b0, 3'd1);
    chk("R8", "src_o", 8'(src_o), 8'd1);

    // R7 access modes
    write_mode(3'd6, 1'b1);
    chk("R7", "meas_req_o", 8'(meas_req_o), 8'd0);
    chk("R7", "acc", 8'({acc_zs_o, acc_fs_o}), 8'b10);
    pulse_done();
    chk_pulses("R7", 1'b0, 1'b0, 1'b0, 3'd6);
    write_mode(3'd7, 1'b1);
    chk("R7", "acc", 8'({acc_zs_o, acc_fs_o}), 8'b01);
    pulse_done();
    chk_pulses("R7", 1'b0, 1'b0, 1'b0, 3'd7);

    // R9 channel held while ch_i changes
    write_mode(3'd2, 1'b1);
    ch_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R9", "ch_o", 8'(ch_o), 8'd1);

    // R1 reset during background
    write_mode(3'd5, 1'b1);
    pulse_done();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "mode_o", 8'(mode_o), 8'd0);
    chk("R1", "ch_o", 8'(ch_o), 8'd0);
    chk("R1", "src_o", 8'(src_o), 8'd0);
    rst_ni = 1'b1;

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule